// File: doc/BRIEF.md
# Submission and Completion Ring Engine

This block is the hardware side of a doorbell-driven pair of rings for memory copy work. Software fills fixed-size 32-byte descriptors into a submission ring and announces them by writing a new tail index. The engine owns the submission head: whenever the head and the software tail differ, it reads the descriptor at the head slot one 32-bit word at a time and decodes it. A copy descriptor hands its source, destination and byte length to an external copy engine and waits for that engine to finish.

After each descriptor the engine writes a 16-byte completion entry into the completion ring at its own completion tail. If the descriptor asked for it, the engine then pulses an interrupt. Software frees completion slots by writing the completion head index. Descriptors are handled strictly in ring order, one at a time. Both rings take their size as an entry count minus one, and every index wraps to zero after that value. Descriptor and completion storage sit outside the block behind a word-addressed read port and a word-addressed write port.

Top module: `ring_cmd_engine`

## Requirements
- R1: While `rst_n` is low, `sq_head` and `cq_tail` are 0 and `dr_req`, `cp_req`, `cw_en` and `irq` are all 0.
- R2: When `sq_head` equals `db_sq_tail`, the engine issues no descriptor reads.
- R3: For pending work, the engine reads the 8 words of the head descriptor at word address `sq_head*8 + k` (read data returns one cycle after `dr_req`). Word 0 bits 3:0 hold the opcode, word 3 the byte length, words 4/5 the low/high source address and words 6/7 the low/high destination address. Opcode 4 raises `cp_req` with `cp_src`, `cp_dst` and `cp_len` taken from those words, and holds it until a `cp_done` pulse.
- R4: Each completion is 4 words written at word address `cq_tail*4 + k`. Words 0 and 1 are zero. Word 2 bits 15:0 hold the submission head index that follows the completed descriptor, and its upper bits are zero. Word 3 bits 15:0 are zero, bit 16 is the valid flag (always 1), and bits 31:17 are the 15-bit status (0 = success).
- R5: Any opcode other than 4 (for example 1, 0 or 15) never raises `cp_req` and completes with status 1.
- R6: `irq` pulses for exactly one cycle after a completion has been written, and only when bit 8 of descriptor word 0 is set.
- R7: `sq_head` and `cq_tail` each move by one only after the completion words have been written. Each wraps to 0 after reaching its programmed last index (`cfg_sq_last`, `cfg_cq_last` = entry count minus one).
- R8: While advancing `cq_tail` would make it equal to `db_cq_head`, no completion is written and `sq_head` does not move. Work resumes once software moves the completion head.
- R9: At most one of `dr_req`, `cp_req` and `cw_en` is high in any cycle.
- R10: The attribute fields (word 0 bits 14:12, word 2 bits 26:24) and word 1 do not affect the copy request or the completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sq_last | input | IW | Submission ring entry count minus one |
| cfg_cq_last | input | IW | Completion ring entry count minus one |
| db_sq_tail | input | IW | Software-written submission tail (doorbell) |
| db_cq_head | input | IW | Software-written completion head |
| sq_head | output | IW | Hardware submission head index |
| cq_tail | output | IW | Hardware completion tail index |
| dr_req | output | 1 | Descriptor word read request |
| dr_addr | output | IW+3 | Descriptor word address |
| dr_data | input | 32 | Read data, valid one cycle after the request |
| cp_req | output | 1 | Copy request, held until done |
| cp_src | output | 64 | Copy source address |
| cp_dst | output | 64 | Copy destination address |
| cp_len | output | 32 | Copy byte length |
| cp_done | input | 1 | Copy finished pulse |
| cw_en | output | 1 | Completion word write enable |
| cw_addr | output | IW+2 | Completion word address |
| cw_data | output | 32 | Completion word data |
| irq | output | 1 | Completion interrupt pulse |

## Verification
Every cycle the assertions check that the three memory-side ports are mutually exclusive and that a fetch starts only with work pending. They also check that the head moves by exactly one wrapped step, two cycles after a completion write. Finally they check that an interrupt follows a write and that no completion is written into a full ring. Only the bench scenarios can show the descriptor decode, that is, the copy fields and the status chosen for each opcode. The same holds for the exact completion word layout, interrupt gating by the enable bit, wrap over several laps of a four-entry ring, and the resume after a full-ring stall.

// File: rtl/rce_pkg.sv
package rce_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_DECODE, ST_COPY, ST_CQWAIT, ST_WRITE, ST_ADV
  } rce_state_e;

  localparam int DESC_WORDS = 8;
  localparam int CPL_WORDS  = 4;
  localparam int DW_W       = $clog2(DESC_WORDS);
  localparam int CW_W       = $clog2(CPL_WORDS);
  localparam logic [3:0]  OP_COPY    = 4'h4;
  localparam logic [14:0] STS_OK     = 15'd0;
  localparam logic [14:0] STS_BAD_OP = 15'd1;
  localparam int IE_BIT     = 8;
endpackage

// File: rtl/rce_wrap_idx.sv
module rce_wrap_idx #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic [W-1:0] last,
  output logic [W-1:0] idx,
  output logic [W-1:0] nxt
);
  logic [W-1:0] idx_q;

  always_comb begin
    nxt = (idx_q == last) ? '0 : idx_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   idx_q <= '0;
    else if (inc) idx_q <= nxt;
  end

  assign idx = idx_q;
endmodule

// File: rtl/rce_desc_regs.sv
module rce_desc_regs
  import rce_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vld,
  input  logic [DW_W-1:0] widx,
  input  logic [31:0]     data,
  output logic [3:0]      op,
  output logic            ie,
  output logic [31:0]     len,
  output logic [63:0]     src,
  output logic [63:0]     dst
);
  logic [3:0]  op_q;
  logic        ie_q;
  logic [31:0] len_q;
  logic [63:0] src_q, dst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= '0;
      ie_q  <= 1'b0;
      len_q <= '0;
      src_q <= '0;
      dst_q <= '0;
    end else if (vld) begin
      case (widx)
        DW_W'(0): begin op_q <= data[3:0]; ie_q <= data[IE_BIT]; end
        DW_W'(3): len_q <= data;
        DW_W'(4): src_q[31:0]  <= data;
        DW_W'(5): src_q[63:32] <= data;
        DW_W'(6): dst_q[31:0]  <= data;
        DW_W'(7): dst_q[63:32] <= data;
        default: ;
      endcase
    end
  end

  assign op  = op_q;
  assign ie  = ie_q;
  assign len = len_q;
  assign src = src_q;
  assign dst = dst_q;
endmodule

// File: rtl/rce_ctrl.sv
module rce_ctrl
  import rce_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            work,
  input  logic            op_copy,
  input  logic            cp_done,
  input  logic            cq_room,
  output logic            rd_req,
  output logic [DW_W-1:0] rd_word,
  output logic            rd_vld,
  output logic [DW_W-1:0] rd_idx,
  output logic            cp_req,
  output logic            wr_en,
  output logic [CW_W-1:0] wr_word,
  output logic            adv,
  output logic            bad_op
);
  rce_state_e      state_q, state_d;
  logic [DW_W-1:0] cnt_q, cnt_d;
  logic            bad_q, bad_d;
  logic            rd_vld_q;
  logic [DW_W-1:0] rd_idx_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bad_d   = bad_q;
    case (state_q)
      ST_IDLE:   if (work) begin state_d = ST_FETCH; cnt_d = '0; end
      ST_FETCH: begin
        cnt_d = cnt_q + DW_W'(1);
        if (cnt_q == DW_W'(DESC_WORDS - 1)) state_d = ST_DECODE;
      end
      ST_DECODE: begin
        bad_d   = !op_copy;
        state_d = op_copy ? ST_COPY : ST_CQWAIT;
      end
      ST_COPY:   if (cp_done) state_d = ST_CQWAIT;
      ST_CQWAIT: if (cq_room) begin state_d = ST_WRITE; cnt_d = '0; end
      ST_WRITE: begin
        cnt_d = cnt_q + DW_W'(1);
        if (cnt_q == DW_W'(CPL_WORDS - 1)) state_d = ST_ADV;
      end
      ST_ADV:    state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      bad_q    <= 1'b0;
      rd_vld_q <= 1'b0;
      rd_idx_q <= '0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      bad_q    <= bad_d;
      rd_vld_q <= rd_req;
      if (rd_req) rd_idx_q <= cnt_q;
    end
  end

  assign rd_req  = (state_q == ST_FETCH);
  assign rd_word = cnt_q;
  assign rd_vld  = rd_vld_q;
  assign rd_idx  = rd_idx_q;
  assign cp_req  = (state_q == ST_COPY);
  assign wr_en   = (state_q == ST_WRITE);
  assign wr_word = cnt_q[CW_W-1:0];
  assign adv     = (state_q == ST_ADV);
  assign bad_op  = bad_q;
endmodule

// File: rtl/ring_cmd_engine.sv
module ring_cmd_engine
  import rce_pkg::*;
#(
  parameter int IW = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IW-1:0]   cfg_sq_last,
  input  logic [IW-1:0]   cfg_cq_last,
  input  logic [IW-1:0]   db_sq_tail,
  input  logic [IW-1:0]   db_cq_head,
  output logic [IW-1:0]   sq_head,
  output logic [IW-1:0]   cq_tail,
  output logic            dr_req,
  output logic [IW+2:0]   dr_addr,
  input  logic [31:0]     dr_data,
  output logic            cp_req,
  output logic [63:0]     cp_src,
  output logic [63:0]     cp_dst,
  output logic [31:0]     cp_len,
  input  logic            cp_done,
  output logic            cw_en,
  output logic [IW+1:0]   cw_addr,
  output logic [31:0]     cw_data,
  output logic            irq
);
  localparam int HEAD_PAD = 16 - IW;

  logic [IW-1:0]   sq_nxt, cq_nxt;
  logic            adv, bad_op, rd_vld, d_ie;
  logic [DW_W-1:0] rd_word, rd_idx;
  logic [CW_W-1:0] wr_word;
  logic [3:0]      d_op;
  logic [14:0]     status;

  rce_wrap_idx #(.W(IW)) u_sq_idx (
    .clk(clk), .rst_n(rst_n), .inc(adv), .last(cfg_sq_last),
    .idx(sq_head), .nxt(sq_nxt));

  rce_wrap_idx #(.W(IW)) u_cq_idx (
    .clk(clk), .rst_n(rst_n), .inc(adv), .last(cfg_cq_last),
    .idx(cq_tail), .nxt(cq_nxt));

  rce_desc_regs u_desc (
    .clk(clk), .rst_n(rst_n), .vld(rd_vld), .widx(rd_idx), .data(dr_data),
    .op(d_op), .ie(d_ie), .len(cp_len), .src(cp_src), .dst(cp_dst));

  rce_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .work(sq_head != db_sq_tail), .op_copy(d_op == OP_COPY),
    .cp_done(cp_done), .cq_room(cq_nxt != db_cq_head),
    .rd_req(dr_req), .rd_word(rd_word), .rd_vld(rd_vld), .rd_idx(rd_idx),
    .cp_req(cp_req), .wr_en(cw_en), .wr_word(wr_word), .adv(adv),
    .bad_op(bad_op));

  assign dr_addr = {sq_head, rd_word};
  assign cw_addr = {cq_tail, wr_word};
  assign status  = bad_op ? STS_BAD_OP : STS_OK;

  always_comb begin
    case (wr_word)
      CW_W'(2): cw_data = {16'h0, {HEAD_PAD{1'b0}}, sq_nxt};
      CW_W'(3): cw_data = {status, 1'b1, 16'h0};
      default:  cw_data = 32'h0;
    endcase
  end

  assign irq = adv & d_ie;
endmodule

// File: rtl/rce_sva.sv
module rce_sva #(
  parameter int IW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dr_req,
  input logic          cp_req,
  input logic          cw_en,
  input logic          irq,
  input logic [IW-1:0] sq_head,
  input logic [IW-1:0] db_sq_tail,
  input logic [IW-1:0] cfg_sq_last,
  input logic [IW-1:0] cq_tail,
  input logic [IW-1:0] cfg_cq_last,
  input logic [IW-1:0] db_cq_head
);
  logic [IW-1:0] cq_step;
  assign cq_step = (cq_tail == cfg_cq_last) ? '0 : cq_tail + IW'(1);

  AST_ONE_PORT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dr_req, cp_req, cw_en})); // R9
  AST_FETCH_NEEDS_WORK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dr_req) |-> (sq_head != db_sq_tail)); // R2
  AST_HEAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_head != $past(sq_head)) |->
      (sq_head == (($past(sq_head) == $past(cfg_sq_last)) ? '0 : IW'($past(sq_head) + IW'(1))))); // R7
  AST_HEAD_AFTER_CPL: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_head != $past(sq_head)) |-> $past(cw_en, 2)); // R7
  AST_IRQ_AFTER_CPL: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(cw_en) && !cw_en)); // R6
  AST_NO_CPL_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cw_en) |-> (cq_step != db_cq_head)); // R8
endmodule

bind ring_cmd_engine rce_sva #(.IW(IW)) u_sva (
  .clk(clk), .rst_n(rst_n), .dr_req(dr_req), .cp_req(cp_req), .cw_en(cw_en),
  .irq(irq), .sq_head(sq_head), .db_sq_tail(db_sq_tail),
  .cfg_sq_last(cfg_sq_last), .cq_tail(cq_tail), .cfg_cq_last(cfg_cq_last),
  .db_cq_head(db_cq_head));

// File: tb/ring_cmd_engine_tb.sv
module ring_cmd_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int IW   = 3;
  localparam int RING = 4;

  typedef struct packed {
    logic [3:0]  op;
    logic        ie;
    logic [2:0]  attr;
    logic [31:0] len;
    logic [63:0] src;
    logic [63:0] dst;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{4'h4, 1'b1, 3'd0, 32'h0000_0040, 64'h1000_0000_0000_0100, 64'h2000_0000_0000_0200},
    '{4'h1, 1'b1, 3'd0, 32'h0000_0010, 64'h0000_0000_0000_0300, 64'h0000_0000_0000_0400},
    '{4'h4, 1'b0, 3'd5, 32'h0000_1000, 64'hA5A5_0000_1234_5678, 64'h5A5A_FFFF_8765_4321},
    '{4'hF, 1'b0, 3'd2, 32'h0000_0008, 64'h0000_0000_0000_0500, 64'h0000_0000_0000_0600},
    '{4'h4, 1'b1, 3'd7, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFF0, 64'h0123_4567_89AB_CDEF},
    '{4'h0, 1'b1, 3'd1, 32'h0000_0001, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0002}
  };

  logic          clk, rst_n;
  logic [IW-1:0] cfg_sq_last, cfg_cq_last, db_sq_tail, db_cq_head;
  logic [IW-1:0] sq_head, cq_tail;
  logic          dr_req, cp_req, cp_done, cw_en, irq;
  logic [IW+2:0] dr_addr;
  logic [IW+1:0] cw_addr;
  logic [31:0]   dr_data, cw_data, cp_len;
  logic [63:0]   cp_src, cp_dst;

  ring_cmd_engine #(.IW(IW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_sq_last(cfg_sq_last), .cfg_cq_last(cfg_cq_last),
    .db_sq_tail(db_sq_tail), .db_cq_head(db_cq_head), .sq_head(sq_head),
    .cq_tail(cq_tail), .dr_req(dr_req), .dr_addr(dr_addr), .dr_data(dr_data),
    .cp_req(cp_req), .cp_src(cp_src), .cp_dst(cp_dst), .cp_len(cp_len),
    .cp_done(cp_done), .cw_en(cw_en), .cw_addr(cw_addr), .cw_data(cw_data),
    .irq(irq));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] desc_mem [64];
  logic [31:0] cpl_mem  [32];
  logic [31:0] rd_q;
  int n_reads, n_writes, n_irq, n_copy, n_overlap, cyc;
  logic [2:0]  cp_cnt;
  logic        cp_req_d;
  logic [63:0] cap_src, cap_dst;
  logic [31:0] cap_len;
  int checks, fails;
  bit done_flag;

  assign dr_data = rd_q;

  always @(posedge clk) begin
    rd_q <= desc_mem[dr_addr];
    if (cw_en) cpl_mem[cw_addr] <= cw_data;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cp_cnt <= '0; cp_done <= 1'b0; cp_req_d <= 1'b0;
      n_reads <= 0; n_writes <= 0; n_irq <= 0; n_copy <= 0; n_overlap <= 0;
      cap_src <= '0; cap_dst <= '0; cap_len <= '0;
    end else begin
      cp_done  <= 1'b0;
      cp_req_d <= cp_req;
      if (cp_req && !cp_done) begin
        if (cp_cnt == 3'd3) begin cp_done <= 1'b1; cp_cnt <= '0; end
        else cp_cnt <= cp_cnt + 3'd1;
      end
      if (cp_req && !cp_req_d) begin
        n_copy <= n_copy + 1; cap_src <= cp_src; cap_dst <= cp_dst; cap_len <= cp_len;
      end
      if (dr_req) n_reads <= n_reads + 1;
      if (cw_en) n_writes <= n_writes + 1;
      if (irq) n_irq <= n_irq + 1;
      if (32'(dr_req) + 32'(cp_req) + 32'(cw_en) > 1) n_overlap <= n_overlap + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        finish_run();
      end
    end
  end

  task automatic put_desc(input int slot, input vec_t v);
    desc_mem[slot*8 + 0] = {17'h0, v.attr, 3'h0, v.ie, 4'h0, v.op};
    desc_mem[slot*8 + 1] = 32'hDEAD_BEEF;
    desc_mem[slot*8 + 2] = {5'h0, v.attr, 24'h00C0DE};
    desc_mem[slot*8 + 3] = v.len;
    desc_mem[slot*8 + 4] = v.src[31:0];
    desc_mem[slot*8 + 5] = v.src[63:32];
    desc_mem[slot*8 + 6] = v.dst[31:0];
    desc_mem[slot*8 + 7] = v.dst[63:32];
  endtask

  task automatic wait_head(input logic [IW-1:0] target);
    for (int k = 0; k < 300 && sq_head != target; k++) @(negedge clk);
  endtask

  initial begin
    int h, t, nh, nt, c0, i0, w0;
    logic [14:0] sts;
    checks = 0; fails = 0; done_flag = 1'b0;
    for (int k = 0; k < 64; k++) desc_mem[k] = '0;
    rst_n = 1'b0;
    cfg_sq_last = IW'(RING - 1); cfg_cq_last = IW'(RING - 1);
    db_sq_tail = '0; db_cq_head = '0;
    repeat (3) @(negedge clk);
    // R1: idle outputs under reset
    check(sq_head == 0 && cq_tail == 0, "R1 indices", {sq_head, cq_tail}, 0);
    check({dr_req, cp_req, cw_en, irq} == 4'b0, "R1 strobes",
          {dr_req, cp_req, cw_en, irq}, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    // R2: empty ring, no reads
    check(n_reads == 0, "R2 no fetch when empty", n_reads, 0);

    h = 0; t = 0;
    for (int i = 0; i < NV; i++) begin
      put_desc(h, VECS[i]);
      c0 = n_copy; i0 = n_irq;
      nh = (h + 1) % RING; nt = (t + 1) % RING;
      db_sq_tail = IW'(nh);
      wait_head(IW'(nh));
      @(negedge clk);
      check(sq_head == IW'(nh), "R7 head step/wrap", sq_head, nh);
      check(cq_tail == IW'(nt), "R7 tail step/wrap", cq_tail, nt);
      if (VECS[i].op == 4'h4) begin
        check(n_copy == c0 + 1, "R3 copy issued", n_copy - c0, 1);
        check(cap_src == VECS[i].src, "R3 R10 copy src", cap_src, VECS[i].src);
        check(cap_dst == VECS[i].dst, "R3 R10 copy dst", cap_dst, VECS[i].dst);
        check(cap_len == VECS[i].len, "R3 copy len", cap_len, VECS[i].len);
        sts = 15'd0;
      end else begin
        check(n_copy == c0, "R5 no copy for other opcode", n_copy - c0, 0);
        sts = 15'd1;
      end
      check(cpl_mem[t*4 + 0] == 0 && cpl_mem[t*4 + 1] == 0, "R4 words 0/1",
            {cpl_mem[t*4 + 0], cpl_mem[t*4 + 1]}, 0);
      check(cpl_mem[t*4 + 2] == 32'(nh), "R4 head echo", cpl_mem[t*4 + 2], nh);
      check(cpl_mem[t*4 + 3] == {sts, 1'b1, 16'h0}, "R4 R5 valid/status",
            cpl_mem[t*4 + 3], {sts, 1'b1, 16'h0});
      check(n_irq - i0 == int'(VECS[i].ie), "R6 irq gating", n_irq - i0, VECS[i].ie);
      db_cq_head = IW'(nt);
      h = nh; t = nt;
    end

    // R8: completion ring full stalls the engine
    db_cq_head = IW'((t + 1) % RING);
    put_desc(h, VECS[3]);
    w0 = n_writes; i0 = n_irq;
    nh = (h + 1) % RING;
    db_sq_tail = IW'(nh);
    repeat (60) @(negedge clk);
    check(sq_head == IW'(h), "R8 head held while full", sq_head, h);
    check(n_writes == w0, "R8 no write while full", n_writes - w0, 0);
    db_cq_head = IW'(t);
    wait_head(IW'(nh));
    @(negedge clk);
    check(sq_head == IW'(nh), "R8 resume after free", sq_head, nh);
    check(cpl_mem[t*4 + 3] == {15'd1, 1'b1, 16'h0}, "R8 entry after resume",
          cpl_mem[t*4 + 3], {15'd1, 1'b1, 16'h0});
    check(n_irq == i0, "R6 no irq without enable", n_irq - i0, 0);
    // R9: ports never active together
    check(n_overlap == 0, "R9 exclusive ports", n_overlap, 0);
    finish_run();
  end
endmodule